// File: doc/BRIEF.md
# Planar Frame Buffer Write Datapath

This block forms the data for one CPU write into a frame buffer that is split into four byte-wide planes. A write request carries one CPU byte. The block combines that byte with the four bytes held in the read latches and with a set of control fields, and it produces one output byte per plane plus a plane write enable. A 2-bit mode field chooses one of four ways to build the plane bytes:

- rotate the CPU byte, or substitute per-plane set/reset constants;
- copy the latches unchanged;
- spread one CPU bit across each plane;
- use set/reset constants under a mask derived from the rotated CPU byte.

The control fields are a rotate amount, a logic operation against the latches, per-plane set/reset values and enables, a plane mask and a bit mask.

A request is captured on a rising clock edge. The result appears on registered outputs one cycle later, together with a valid strobe. A memory controller writes `planeData` into every plane whose `planeWe` bit is set. Plane p always occupies bits [8p+7:8p] of the 32-bit latch and data buses. Address decoding and the memory itself are outside this block.

Top module: `planar_write_path`

## Requirements
- R1: When `wrReq` is high at a rising edge, `wrValid` is high for the cycle that follows that edge. When `wrReq` is low, `wrValid` is low in the following cycle.
- R2: In a valid cycle, `planeWe` equals the `planeMask` that was captured with the request. Otherwise `planeWe` is 0. `planeData` holds its value across cycles with no request.
- R3: In mode 1 (`writeMode`=01), each plane byte equals its latch byte. The bit mask, the logic operation and the CPU byte have no effect.
- R4: In modes 0 and 3, the CPU byte is rotated right by `rotateCount`, from 0 to 7 positions. Rotated bit i is CPU bit (i+count) mod 8.
- R5: In mode 0 (`writeMode`=00), plane p uses the rotated byte as its source when `setResetEn[p]` is 0. When `setResetEn[p]` is 1, it uses `setResetVal[p]` replicated to 8 bits.
- R6: In modes 0, 2 and 3, the source byte is combined with the latch byte by `logicOp`: 00 passes the source, 01 ANDs, 10 ORs and 11 XORs.
- R7: In mode 2 (`writeMode`=10), the source for plane p is CPU bit p replicated to 8 bits.
- R8: In mode 3 (`writeMode`=11), the source for plane p is `setResetVal[p]` replicated to 8 bits, and `setResetEn` is ignored. The protection mask is the rotated CPU byte ANDed with `bitMask`.
- R9: In modes 0 and 2, a `bitMask` bit of 1 lets the combined value through. A bit of 0 keeps the latch bit in that position. In mode 3, the same rule applies using the mask from R8.
- R10: While `rstN` is low, `wrValid`, `planeWe` and `planeData` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| wrReq | input | 1 | CPU write request for this cycle |
| cpuData | input | 8 | CPU write byte |
| latchData | input | 32 | Latched plane bytes, plane p at [8p+7:8p] |
| writeMode | input | 2 | Write mode 0 to 3 |
| rotateCount | input | 3 | Right-rotate amount for the CPU byte |
| logicOp | input | 2 | 00 pass, 01 AND, 10 OR, 11 XOR with latch |
| setResetVal | input | 4 | Per-plane set/reset bit |
| setResetEn | input | 4 | Per-plane set/reset enable (mode 0) |
| planeMask | input | 4 | Per-plane write enable mask |
| bitMask | input | 8 | Per-bit update mask |
| wrValid | output | 1 | Result valid this cycle |
| planeData | output | 32 | Plane write bytes, plane p at [8p+7:8p] |
| planeWe | output | 4 | Per-plane write enable |

## Verification
The bench checks the rotate direction with a single set bit rotated by 3. A design that rotated left would place that bit in the wrong position.

It applies each logic operation to a latch pattern with alternating bits, so a swapped operation code yields a different byte. In mode 3 the set/reset enables are deliberately left at 0. A design that still honoured them, or that took the mask from the unrotated byte, would write the wrong bits.

Mode 1 is driven with a zero bit mask. A design that applied the mask in that mode would still match, so the latch copy is also compared against random masks and random controls on every clock.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

  typedef enum logic [1:0] {
    SRC_ROTATED = 2'd0,
    SRC_LATCH   = 2'd1,
    SRC_CPUBIT  = 2'd2,
    SRC_SETRST  = 2'd3
  } srcSel_e;

  typedef enum logic [1:0] {
    OP_PASS = 2'd0,
    OP_AND  = 2'd1,
    OP_OR   = 2'd2,
    OP_XOR  = 2'd3
  } aluOp_e;

  typedef struct packed {
    logic    fire;
    srcSel_e srcSel;
    logic    honorSrEn;
    logic    maskFromRot;
    aluOp_e  aluOp;
  } pathCtrl_t;

endpackage

// File: rtl/pfb_ctrl.sv
module pfb_ctrl
  import pfb_pkg::*;
(
  input  logic       wrReq,
  input  logic [1:0] writeMode,
  input  logic [1:0] logicOp,
  output pathCtrl_t  ctrl
);

  always_comb begin
    ctrl.fire        = wrReq;
    ctrl.aluOp       = aluOp_e'(logicOp);
    ctrl.honorSrEn   = 1'b0;
    ctrl.maskFromRot = 1'b0;
    unique case (writeMode)
      2'b00: begin
        ctrl.srcSel    = SRC_ROTATED;
        ctrl.honorSrEn = 1'b1;
      end
      2'b01: begin
        ctrl.srcSel = SRC_LATCH;
        ctrl.aluOp  = OP_PASS;
      end
      2'b10: ctrl.srcSel = SRC_CPUBIT;
      default: begin
        ctrl.srcSel      = SRC_SETRST;
        ctrl.maskFromRot = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/pfb_datapath.sv
module pfb_datapath
  import pfb_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PLANES = 4,
  localparam int ROT_W = $clog2(BYTE_W),
  localparam int BUS_W = BYTE_W * PLANES
) (
  input  pathCtrl_t          ctrl,
  input  logic [BYTE_W-1:0]  cpuData,
  input  logic [BUS_W-1:0]   latchData,
  input  logic [ROT_W-1:0]   rotateCount,
  input  logic [PLANES-1:0]  setResetVal,
  input  logic [PLANES-1:0]  setResetEn,
  input  logic [BYTE_W-1:0]  bitMask,
  output logic [BUS_W-1:0]   nextData
);

  logic [BYTE_W-1:0]   rotByte;
  logic [2*BYTE_W-1:0] rotWide;
  logic [BYTE_W-1:0]   protMask;

  always_comb begin
    rotWide = {cpuData, cpuData} >> rotateCount;
    rotByte = rotWide[BYTE_W-1:0];
  end

  always_comb begin
    unique case (ctrl.srcSel)
      SRC_LATCH: protMask = '0;
      SRC_SETRST: protMask = ctrl.maskFromRot ? (rotByte & bitMask) : bitMask;
      default:   protMask = bitMask;
    endcase
  end

  for (genvar p = 0; p < PLANES; p++) begin : g_lane
    logic [BYTE_W-1:0] latchByte;
    logic [BYTE_W-1:0] srcByte;
    logic [BYTE_W-1:0] aluByte;

    assign latchByte = latchData[p*BYTE_W +: BYTE_W];

    always_comb begin
      unique case (ctrl.srcSel)
        SRC_ROTATED: srcByte = (ctrl.honorSrEn && setResetEn[p]) ?
                               {BYTE_W{setResetVal[p]}} : rotByte;
        SRC_CPUBIT:  srcByte = {BYTE_W{cpuData[p]}};
        SRC_SETRST:  srcByte = {BYTE_W{setResetVal[p]}};
        default:     srcByte = latchByte;
      endcase
    end

    always_comb begin
      unique case (ctrl.aluOp)
        OP_AND:  aluByte = srcByte & latchByte;
        OP_OR:   aluByte = srcByte | latchByte;
        OP_XOR:  aluByte = srcByte ^ latchByte;
        default: aluByte = srcByte;
      endcase
    end

    assign nextData[p*BYTE_W +: BYTE_W] = (aluByte & protMask) | (latchByte & ~protMask);
  end

endmodule

// File: rtl/planar_write_path.sv
module planar_write_path
  import pfb_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PLANES = 4,
  localparam int ROT_W = $clog2(BYTE_W),
  localparam int BUS_W = BYTE_W * PLANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrReq,
  input  logic [BYTE_W-1:0] cpuData,
  input  logic [BUS_W-1:0]  latchData,
  input  logic [1:0]        writeMode,
  input  logic [ROT_W-1:0]  rotateCount,
  input  logic [1:0]        logicOp,
  input  logic [PLANES-1:0] setResetVal,
  input  logic [PLANES-1:0] setResetEn,
  input  logic [PLANES-1:0] planeMask,
  input  logic [BYTE_W-1:0] bitMask,
  output logic              wrValid,
  output logic [BUS_W-1:0]  planeData,
  output logic [PLANES-1:0] planeWe
);

  pathCtrl_t        ctrl;
  logic [BUS_W-1:0] nextData;

  pfb_ctrl u_ctrl (
    .wrReq     (wrReq),
    .writeMode (writeMode),
    .logicOp   (logicOp),
    .ctrl      (ctrl)
  );

  pfb_datapath #(.BYTE_W(BYTE_W), .PLANES(PLANES)) u_dp (
    .ctrl        (ctrl),
    .cpuData     (cpuData),
    .latchData   (latchData),
    .rotateCount (rotateCount),
    .setResetVal (setResetVal),
    .setResetEn  (setResetEn),
    .bitMask     (bitMask),
    .nextData    (nextData)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrValid   <= 1'b0;
      planeWe   <= '0;
      planeData <= '0;
    end else begin
      wrValid <= ctrl.fire;
      planeWe <= ctrl.fire ? planeMask : '0;
      if (ctrl.fire) planeData <= nextData;
    end
  end

endmodule

// File: rtl/planar_write_path_chk.sv
module planar_write_path_chk #(
  parameter int BYTE_W = 8,
  parameter int PLANES = 4,
  localparam int ROT_W = $clog2(BYTE_W),
  localparam int BUS_W = BYTE_W * PLANES
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrReq,
  input logic [BYTE_W-1:0] cpuData,
  input logic [BUS_W-1:0]  latchData,
  input logic [1:0]        writeMode,
  input logic [ROT_W-1:0]  rotateCount,
  input logic [1:0]        logicOp,
  input logic [PLANES-1:0] setResetVal,
  input logic [PLANES-1:0] setResetEn,
  input logic [PLANES-1:0] planeMask,
  input logic [BYTE_W-1:0] bitMask,
  input logic              wrValid,
  input logic [BUS_W-1:0]  planeData,
  input logic [PLANES-1:0] planeWe
);

  p_valid_follows_req_r1: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |=> wrValid);
  p_no_valid_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !wrReq |=> !wrValid);
  p_we_matches_mask_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |=> planeWe == $past(planeMask));
  p_we_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid |-> planeWe == '0);
  p_data_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !wrReq |=> $stable(planeData));
  p_latch_copy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && writeMode == 2'b01) |=> planeData == $past(latchData));
  p_zero_mask_keeps_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && bitMask == '0) |=> planeData == $past(latchData));

endmodule

bind planar_write_path planar_write_path_chk #(.BYTE_W(BYTE_W), .PLANES(PLANES)) u_chk (.*);

// File: tb/planar_write_path_bench.sv
module planar_write_path_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrReq = 1'b0;
  logic [7:0]  cpuData = '0;
  logic [31:0] latchData = '0;
  logic [1:0]  writeMode = '0;
  logic [2:0]  rotateCount = '0;
  logic [1:0]  logicOp = '0;
  logic [3:0]  setResetVal = '0;
  logic [3:0]  setResetEn = '0;
  logic [3:0]  planeMask = '0;
  logic [7:0]  bitMask = '0;
  logic        wrValid;
  logic [31:0] planeData;
  logic [3:0]  planeWe;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic        expValid = 1'b0;
  logic [3:0]  expWe = '0;
  logic [31:0] expData = '0;
  logic [1:0]  expMode = '0;

  always #4 clk = ~clk;

  planar_write_path u_planar_write_path (.*);

  function automatic logic [31:0] refModel(input logic [7:0] cpu, input logic [31:0] lat,
      input logic [1:0] md, input logic [2:0] rc, input logic [1:0] op,
      input logic [3:0] srv, input logic [3:0] sre, input logic [7:0] bm);
    logic [31:0] res;
    logic [7:0]  rot;
    for (int i = 0; i < 8; i++) rot[i] = cpu[(i + rc) % 8];
    for (int p = 0; p < 4; p++) begin
      for (int b = 0; b < 8; b++) begin
        logic l, s, v, m;
        l = lat[p*8+b];
        case (md)
          2'd0: s = sre[p] ? srv[p] : rot[b];
          2'd2: s = cpu[p];
          2'd3: s = srv[p];
          default: s = l;
        endcase
        case (op)
          2'd1: v = s & l;
          2'd2: v = s | l;
          2'd3: v = s ^ l;
          default: v = s;
        endcase
        if (md == 2'd1) begin
          v = l;
          m = 1'b0;
        end else if (md == 2'd3) m = rot[b] & bm[b];
        else m = bm[b];
        res[p*8+b] = m ? v : l;
      end
    end
    return res;
  endfunction

  function automatic string modeTag(input logic [1:0] md);
    case (md)
      2'd0: return "R5";
      2'd1: return "R3";
      2'd2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      expValid <= 1'b0;
      expWe    <= '0;
      expData  <= '0;
    end else begin
      expValid <= wrReq;
      expWe    <= wrReq ? planeMask : 4'h0;
      if (wrReq) begin
        expData <= refModel(cpuData, latchData, writeMode, rotateCount, logicOp,
                            setResetVal, setResetEn, bitMask);
        expMode <= writeMode;
      end
    end
  end

  // every-clock comparison against the reference model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R1 valid", {63'd0, wrValid}, {63'd0, expValid});
      check("R2 enable", {60'd0, planeWe}, {60'd0, expWe});
      check(modeTag(expMode), {32'd0, planeData}, {32'd0, expData});
    end
  end

  task automatic oneWrite(input logic [7:0] cpu, input logic [31:0] lat, input logic [1:0] md,
      input logic [2:0] rc, input logic [1:0] op, input logic [3:0] srv, input logic [3:0] sre,
      input logic [3:0] pm, input logic [7:0] bm, input logic [31:0] exp, input string tag);
    @(negedge clk);
    wrReq = 1'b1; cpuData = cpu; latchData = lat; writeMode = md; rotateCount = rc;
    logicOp = op; setResetVal = srv; setResetEn = sre; planeMask = pm; bitMask = bm;
    @(negedge clk);
    wrReq = 1'b0;
    check(tag, {32'd0, planeData}, {32'd0, exp});
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    wrReq = 1'b1; planeMask = 4'hF; bitMask = 8'hFF;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset", {31'd0, wrValid, planeWe, planeData}, 64'd0);
    wrReq = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R4 rotate right by 3: 0x01 -> 0x20
    oneWrite(8'h01, 32'h0, 2'd0, 3'd3, 2'd0, 4'h0, 4'h0, 4'hF, 8'hFF, 32'h20202020, "R4 rotate");
    check("R1 strobe", {63'd0, wrValid}, 64'd1);
    // R6 logic operations against alternating latch pattern
    oneWrite(8'hF0, 32'hAAAAAAAA, 2'd0, 3'd0, 2'd1, 4'h0, 4'h0, 4'hF, 8'hFF, 32'hA0A0A0A0, "R6 and");
    oneWrite(8'hF0, 32'hAAAAAAAA, 2'd0, 3'd0, 2'd2, 4'h0, 4'h0, 4'hF, 8'hFF, 32'hFAFAFAFA, "R6 or");
    oneWrite(8'hF0, 32'hAAAAAAAA, 2'd0, 3'd0, 2'd3, 4'h0, 4'h0, 4'hF, 8'hFF, 32'h5A5A5A5A, "R6 xor");
    // R5 set/reset on plane 0 only
    oneWrite(8'h12, 32'h0, 2'd0, 3'd0, 2'd0, 4'h1, 4'h1, 4'hF, 8'hFF, 32'h121212FF, "R5 setreset");
    // R7 and R9: per-plane CPU bit with partial bit mask
    oneWrite(8'h05, 32'h3C3C3C3C, 2'd2, 3'd0, 2'd0, 4'h0, 4'h0, 4'hF, 8'h0F, 32'h303F303F, "R9 mask");
    // R8: enables ignored, mask from rotated byte
    oneWrite(8'h80, 32'h0, 2'd3, 3'd1, 2'd0, 4'h3, 4'h0, 4'hF, 8'hFF, 32'h00004040, "R8 mode3");
    // R3: latch copy with zero bit mask
    oneWrite(8'h77, 32'hDEADBEEF, 2'd1, 3'd5, 2'd3, 4'hF, 4'hF, 4'hF, 8'h00, 32'hDEADBEEF, "R3 copy");
    // R2: partial plane mask then idle
    oneWrite(8'h00, 32'h11223344, 2'd1, 3'd0, 2'd0, 4'h0, 4'h0, 4'hA, 8'hFF, 32'h11223344, "R2 data");
    check("R2 we", {60'd0, planeWe}, 64'hA);
    @(negedge clk);
    check("R2 idle we", {60'd0, planeWe}, 64'h0);
    check("R2 hold", {32'd0, planeData}, 64'h11223344);
    check("R1 idle", {63'd0, wrValid}, 64'd0);

    // random sweep compared on every clock
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      wrReq = ($urandom % 4) != 0;
      cpuData = 8'($urandom); latchData = $urandom; writeMode = 2'($urandom);
      rotateCount = 3'($urandom); logicOp = 2'($urandom); setResetVal = 4'($urandom);
      setResetEn = 4'($urandom); planeMask = 4'($urandom); bitMask = 8'($urandom);
    end
    @(negedge clk);
    wrReq = 1'b0;
    repeat (2) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule